// File: doc/BRIEF.md
# MII Management Serial Master

This block runs management-register transactions towards an Ethernet PHY over the two-wire serial management bus. A host issues one command at a time: a read/write select, a 5-bit PHY address, a 5-bit register number and, for a write, 16 bits of data. The block then produces the whole serial frame on the management clock, the data output and its output enable. For a read, it returns the 16 bits that the PHY shifted back.

The management clock is derived from the system clock. Each half of it lasts `HALF_CYC` system clocks, and the low half comes first. Every frame has the same length: 65 bit times. The bit sequence is as follows:

- a 32-bit preamble of ones;
- start and opcode;
- the two addresses;
- a two-bit turnaround;
- sixteen data bits;
- one final clock bit with the output released.

`busy_o` covers the whole frame. `done_o` pulses once at its end.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Out of reset and whenever no frame is running, `mdc_o`, `mdo_o`, `mdoe_o`, `busy_o` and `done_o` are 0, and `rdata_o` resets to 0.
- R2: During a frame, `mdc_o` stays low for `HALF_CYC` system clocks and then high for `HALF_CYC` system clocks in every bit time, for 65 bit times. `mdo_o` and `mdoe_o` change only at the start of a low half.
- R3: Bit times 0 to 31 carry `mdo_o`=1 with `mdoe_o`=1.
- R4: Bit times 32 and 33 carry 0 then 1. Bit times 34 and 35 carry 1,0 for a read (`rd_i`=1) and 0,1 for a write. All four are driven with `mdoe_o`=1.
- R5: Bit times 36 to 40 carry `phy_addr_i` MSB first, and bit times 41 to 45 carry `reg_addr_i` MSB first, all with `mdoe_o`=1.
- R6: In a write, bit times 46 and 47 have `mdo_o`=0 with `mdoe_o`=0. Bit times 48 to 63 carry `wdata_i` MSB first with `mdoe_o`=1.
- R7: In a read, `mdoe_o` and `mdo_o` are 0 from bit time 46 to 63. `mdi_i` is sampled at the system clock edge that ends the high half of bit times 48 to 63, first bit as MSB. The 16-bit result appears on `rdata_o` together with `done_o`.
- R8: Bit time 64 is a full clock period with `mdo_o`=0 and `mdoe_o`=0.
- R9: After the edge that accepts a command, `busy_o` is 1 for 130·`HALF_CYC` cycles. It then falls on the same edge where `done_o` rises, and `done_o` lasts exactly one cycle.
- R10: A `start_i` seen while `busy_o` is 1 is ignored. The running frame continues unchanged, and no extra frame follows it. A start seen in the `done_o` cycle is accepted.
- R11: `rdata_o` keeps its last read value through write frames and idle time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe, taken when not busy |
| rd_i | input | 1 | 1 = read, 0 = write |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register number |
| wdata_i | input | 16 | Write data |
| mdi_i | input | 1 | Serial data from the PHY |
| rdata_o | output | 16 | Last read result |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| busy_o | output | 1 | Frame in progress |
| mdc_o | output | 1 | Management clock |
| mdo_o | output | 1 | Serial data to the PHY |
| mdoe_o | output | 1 | Output enable for `mdo_o` |

## Verification
Times are counted from the edge that accepts a command. Bit time k occupies cycles 2k·H to 2k·H+2H-1, where H is `HALF_CYC`, and its clock goes high H cycles into that span. Read data is due, together with `done_o`, 130·H cycles after acceptance. The reference model keeps one cycle counter per frame and derives the expected clock level, the expected bit and the expected handshake from that counter. It compares them at every falling system-clock edge, half a period away from the edges where the design updates. The PHY responder changes `mdi_i` only on a falling management clock, so every sampled bit has been stable for a full high half.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_W    = 5;
  localparam int REG_W    = 5;
  localparam int DATA_W   = 16;
  localparam int PRE_BITS = 32;

  // bit-time positions inside a frame
  localparam int START_IDX  = PRE_BITS;
  localparam int OP_IDX     = START_IDX + 2;
  localparam int PHY_IDX    = OP_IDX + 2;
  localparam int REG_IDX    = PHY_IDX + PHY_W;
  localparam int TA_IDX     = REG_IDX + REG_W;
  localparam int DAT_IDX    = TA_IDX + 2;
  localparam int END_IDX    = DAT_IDX + DATA_W;
  localparam int FRAME_BITS = END_IDX + 1;
  localparam int BIT_W      = $clog2(FRAME_BITS + 1);

  typedef logic [BIT_W-1:0] bit_idx_t;

  typedef struct packed {
    logic              rd;
    logic [PHY_W-1:0]  phy;
    logic [REG_W-1:0]  rg;
    logic [DATA_W-1:0] wdata;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_phase_timer.sv
module mdio_phase_timer #(
  parameter int unsigned HALF_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic half_end_o
);
  generate
    if (HALF_CYC <= 1) begin : g_div1
      assign half_end_o = run_i;
    end else begin : g_divn
      localparam int CNT_W = $clog2(HALF_CYC);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              cnt_q <= '0;
        else if (!run_i)          cnt_q <= '0;
        else if (cnt_q == LAST)   cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
      end

      assign half_end_o = run_i && (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/mdio_bit_sched.sv
module mdio_bit_sched
  import mdio_pkg::*;
(
  input  bit_idx_t  idx_i,
  input  mdio_cmd_t cmd_i,
  output logic      mdo_o,
  output logic      oe_o
);
  logic [PHY_W-1:0]  pa_sh;
  logic [REG_W-1:0]  ra_sh;
  logic [DATA_W-1:0] wd_sh;
  int i;

  always_comb begin
    i     = int'(idx_i);
    pa_sh = '0;
    ra_sh = '0;
    wd_sh = '0;
    mdo_o = 1'b0;
    oe_o  = 1'b0;
    if (i < START_IDX) begin
      mdo_o = 1'b1;
      oe_o  = 1'b1;
    end else if (i < OP_IDX) begin
      mdo_o = (i == START_IDX + 1);
      oe_o  = 1'b1;
    end else if (i < PHY_IDX) begin
      mdo_o = cmd_i.rd ? (i == OP_IDX) : (i == OP_IDX + 1);
      oe_o  = 1'b1;
    end else if (i < REG_IDX) begin
      pa_sh = cmd_i.phy >> (PHY_W - 1 - (i - PHY_IDX));
      mdo_o = pa_sh[0];
      oe_o  = 1'b1;
    end else if (i < TA_IDX) begin
      ra_sh = cmd_i.rg >> (REG_W - 1 - (i - REG_IDX));
      mdo_o = ra_sh[0];
      oe_o  = 1'b1;
    end else if (i >= DAT_IDX && i < END_IDX && !cmd_i.rd) begin
      wd_sh = cmd_i.wdata >> (DATA_W - 1 - (i - DAT_IDX));
      mdo_o = wd_sh[0];
      oe_o  = 1'b1;
    end
  end
endmodule

// File: rtl/mdio_shift_in.sv
module mdio_shift_in #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic              commit_i,
  input  logic              mdi_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      rdata_o <= '0;
    end else begin
      if (cap_i)    sh_q    <= {sh_q[DATA_W-2:0], mdi_i};
      if (commit_i) rdata_o <= sh_q;
    end
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int unsigned HALF_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [PHY_W-1:0]  phy_addr_i,
  input  logic [REG_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              mdi_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              mdc_o,
  output logic              mdo_o,
  output logic              mdoe_o
);
  localparam bit_idx_t DAT_I  = bit_idx_t'(DAT_IDX);
  localparam bit_idx_t LAST_I = bit_idx_t'(END_IDX);

  mdio_cmd_t cmd_q, cmd_in, sched_cmd;
  bit_idx_t  bit_idx_q, sched_idx;
  logic busy_q, hi_q, mdc_q, mdo_q, oe_q, done_q;
  logic accept, half_end, sched_mdo, sched_oe, fall, cap, commit;

  assign cmd_in    = '{rd: rd_i, phy: phy_addr_i, rg: reg_addr_i, wdata: wdata_i};
  assign accept    = start_i && !busy_q;
  assign sched_idx = accept ? '0 : bit_idx_q + 1'b1;
  assign sched_cmd = accept ? cmd_in : cmd_q;

  mdio_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (busy_q),
    .half_end_o(half_end)
  );

  mdio_bit_sched u_sched (
    .idx_i(sched_idx),
    .cmd_i(sched_cmd),
    .mdo_o(sched_mdo),
    .oe_o (sched_oe)
  );

  // end of a high half: sample point and bit advance
  assign fall   = busy_q && half_end && hi_q;
  assign cap    = fall && cmd_q.rd && (bit_idx_q >= DAT_I) && (bit_idx_q < LAST_I);
  assign commit = fall && cmd_q.rd && (bit_idx_q == LAST_I);

  mdio_shift_in #(.DATA_W(DATA_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap),
    .commit_i(commit),
    .mdi_i   (mdi_i),
    .rdata_o (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q     <= '0;
      bit_idx_q <= '0;
      busy_q    <= 1'b0;
      hi_q      <= 1'b0;
      mdc_q     <= 1'b0;
      mdo_q     <= 1'b0;
      oe_q      <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        cmd_q     <= cmd_in;
        busy_q    <= 1'b1;
        bit_idx_q <= '0;
        hi_q      <= 1'b0;
        mdc_q     <= 1'b0;
        mdo_q     <= sched_mdo;
        oe_q      <= sched_oe;
      end else if (busy_q && half_end) begin
        if (!hi_q) begin
          mdc_q <= 1'b1;
          hi_q  <= 1'b1;
        end else begin
          mdc_q <= 1'b0;
          hi_q  <= 1'b0;
          if (bit_idx_q == LAST_I) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            mdo_q  <= 1'b0;
            oe_q   <= 1'b0;
          end else begin
            bit_idx_q <= bit_idx_q + 1'b1;
            mdo_q     <= sched_mdo;
            oe_q      <= sched_oe;
          end
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign mdc_o  = mdc_q;
  assign mdo_o  = mdo_q;
  assign mdoe_o = oe_q;
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk #(
  parameter int unsigned HALF_CYC = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic done_o,
  input logic mdc_o,
  input logic mdo_o,
  input logic mdoe_o
);
  localparam int CW = $clog2(HALF_CYC + 2) + 1;
  localparam logic [CW-1:0] HC = CW'(HALF_CYC);

  logic mdc_q, seen_q, tog;
  logic [CW-1:0] run_q;

  assign tog = mdc_o != mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mdc_q  <= 1'b0;
      seen_q <= 1'b0;
      run_q  <= '0;
    end else begin
      mdc_q <= mdc_o;
      if (tog)              run_q <= CW'(1);
      else if (run_q != '1) run_q <= run_q + 1'b1;
      if (!busy_o)          seen_q <= 1'b0;
      else if (tog)         seen_q <= 1'b1;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mdc_o && !mdo_o && !mdoe_o));

  assert_half_period_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tog && seen_q) |-> (run_q == HC));

  assert_released_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mdoe_o |-> !mdo_o);

  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_busy_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  assert_done_after_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .busy_o(busy_o),
  .done_o(done_o),
  .mdc_o (mdc_o),
  .mdo_o (mdo_o),
  .mdoe_o(mdoe_o)
);

// File: tb/tb_mdio_mgmt_master.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_master;
  localparam int H  = 2;
  localparam int FR = 2 * H * 65;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, rd = 1'b0;
  logic [4:0] pa = '0, ra = '0;
  logic [15:0] wd = '0;
  logic mdi = 1'b1;
  logic [15:0] rdata;
  logic done, busy, mdc, mdo, mdoe;

  int checks = 0;
  int errors = 0;
  string ctx = "";

  always #2.5 clk = ~clk;

  mdio_mgmt_master #(.HALF_CYC(H)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rd_i(rd),
    .phy_addr_i(pa), .reg_addr_i(ra), .wdata_i(wd), .mdi_i(mdi),
    .rdata_o(rdata), .done_o(done), .busy_o(busy),
    .mdc_o(mdc), .mdo_o(mdo), .mdoe_o(mdoe)
  );

  function automatic logic [15:0] init_val(int i);
    return 16'((i * 40503) ^ 23100);
  endfunction

  // behavioural PHY responder
  logic [15:0] phy_mem [1024];
  logic [63:0] ph_sh = '0;
  int   ph_rc = 0;
  logic ph_rd = 1'b0;
  logic [9:0] ph_addr = '0;

  initial for (int i = 0; i < 1024; i++) phy_mem[i] = init_val(i);

  always @(posedge mdc) begin
    ph_sh = {ph_sh[62:0], mdo};
    if (ph_rc == 45) begin
      ph_rd   = (ph_sh[11:10] == 2'b10);
      ph_addr = ph_sh[9:0];
    end
    if (ph_rc == 63 && !ph_rd) phy_mem[ph_addr] = ph_sh[15:0];
    ph_rc = (ph_rc == 64) ? 0 : ph_rc + 1;
  end

  always @(negedge mdc) begin
    if (ph_rd && ph_rc >= 48 && ph_rc <= 63) mdi = phy_mem[ph_addr][63 - ph_rc];
    else mdi = 1'b1;
  end

  // reference model
  logic [15:0] shadow [1024];
  initial for (int i = 0; i < 1024; i++) shadow[i] = init_val(i);

  logic m_on = 1'b0, m_rd = 1'b0;
  int   m_t = 0;
  logic [15:0] m_exp = '0, m_rdata = '0;
  logic f_mdo [65];
  logic f_oe  [65];

  function automatic string tag_of(int k);
    if (k < 32) return "R3";
    if (k < 36) return "R4";
    if (k < 46) return "R5";
    if (k < 64) return m_rd ? "R7" : "R6";
    return "R8";
  endfunction

  task automatic chk(string tg, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s%s %s t=%0d got %h exp %h", tg, ctx, what, m_t, act, exp);
    end
  endtask

  task automatic compare();
    logic e_mdc, e_mdo, e_oe, e_busy, e_done;
    string tg;
    int k;
    if (m_on && m_t < FR) begin
      k = m_t / (2 * H);
      e_mdc = (m_t % (2 * H)) >= H;
      e_mdo = f_mdo[k]; e_oe = f_oe[k];
      e_busy = 1'b1; e_done = 1'b0;
      tg = tag_of(k);
    end else begin
      e_mdc = 1'b0; e_mdo = 1'b0; e_oe = 1'b0; e_busy = 1'b0;
      e_done = m_on;
      tg = "R1";
      if (m_on && m_rd) m_rdata = m_exp;
    end
    chk("R2", "mdc", 16'(mdc), 16'(e_mdc));
    chk(tg, "mdo", 16'(mdo), 16'(e_mdo));
    chk(tg, "mdoe", 16'(mdoe), 16'(e_oe));
    chk("R9", "busy", 16'(busy), 16'(e_busy));
    chk("R9", "done", 16'(done), 16'(e_done));
    chk(m_on ? "R7" : "R11", "rdata", rdata, m_rdata);
  endtask

  task automatic tick(logic st, logic r, logic [4:0] p, logic [4:0] g, logic [15:0] w);
    logic [63:0] fv, fo;
    start = st; rd = r; pa = p; ra = g; wd = w;
    if (st && !(m_on && m_t < FR)) begin
      fv = {32'hFFFF_FFFF, 2'b01, r ? 2'b10 : 2'b01, p, g, 2'b00, r ? 16'h0 : w};
      fo = {{46{1'b1}}, 2'b00, {16{~r}}};
      for (int k = 0; k < 64; k++) begin
        f_mdo[k] = fv[63-k];
        f_oe[k]  = fo[63-k];
      end
      f_mdo[64] = 1'b0; f_oe[64] = 1'b0;
      m_on = 1'b1; m_t = 0; m_rd = r;
      if (r) m_exp = shadow[{p, g}];
      else   shadow[{p, g}] = w;
    end else if (m_on) begin
      if (m_t == FR) m_on = 1'b0;
      else m_t++;
    end
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 5'd0, 5'd0, 16'h0);
  endtask

  task automatic run(logic r, logic [4:0] p, logic [4:0] g, logic [15:0] w);
    tick(1'b1, r, p, g, w);
    while (m_on) tick(1'b0, r, p, g, w);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare();                       // R1 state while in reset
    rst_n = 1'b1;
    idle(3);                         // R1 after reset release

    run(1'b0, 5'd1, 5'd4, 16'hA5C3); // R6 write frame
    run(1'b1, 5'd1, 5'd4, 16'h0);    // R7 read back
    run(1'b1, 5'd0, 5'd0, 16'h0);    // R5 all-zero addresses
    run(1'b1, 5'd31, 5'd31, 16'h0);  // R5 all-one addresses
    run(1'b1, 5'd10, 5'd21, 16'h0);
    run(1'b0, 5'd21, 5'd10, 16'hFFFF);
    idle(5);                         // R11 rdata held over write
    run(1'b1, 5'd21, 5'd10, 16'h0);
    run(1'b0, 5'd21, 5'd10, 16'h0000);
    run(1'b1, 5'd21, 5'd10, 16'h0);

    // R10: start during a frame is ignored
    ctx = " (R10)";
    tick(1'b1, 1'b0, 5'd9, 5'd9, 16'h1234);
    for (int i = 0; i < 40; i++) tick(1'b0, 1'b0, 5'd9, 5'd9, 16'h1234);
    tick(1'b1, 1'b1, 5'd2, 5'd2, 16'h0);
    for (int i = 0; i < 150; i++) tick(1'b0, 1'b0, 5'd0, 5'd0, 16'h0);
    tick(1'b1, 1'b1, 5'd3, 5'd3, 16'h0);
    while (m_on) tick(1'b0, 1'b0, 5'd0, 5'd0, 16'h0);
    idle(4);

    // R10: start in the done cycle is taken at once
    tick(1'b1, 1'b1, 5'd7, 5'd3, 16'h0);
    while (!(m_on && m_t == FR)) tick(1'b0, 1'b0, 5'd0, 5'd0, 16'h0);
    tick(1'b1, 1'b1, 5'd9, 5'd9, 16'h0);
    while (m_on) tick(1'b0, 1'b0, 5'd0, 5'd0, 16'h0);
    ctx = "";
    idle(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, got hang exp end");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule